// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Priority Controller

This block sits between a set of peripheral interrupt sources and an 8051-style processor core and decides which pending request the core should take next. The sources are bundled into six priority groups, and each group is assigned one of four levels. Level 3 is the highest. A group's level is formed from one bit of a "high" priority register and the matching bit of a "low" priority register. Request flags are latched from hardware set pulses and held until software clears them. Each flag is gated by its own enable. Among the enabled pending flags, the highest level wins. When levels are equal, the lowest source index wins.

The block tracks which levels are in service with a four-bit mask, so that only a strictly higher level can interrupt a running handler. The core acknowledges the offered request with `ack`, which marks that request's level as in service. It signals a return from interrupt with `reti`, which retires the highest level in service. The low priority register also holds two extra bits. One is a watchdog overflow status bit that software can clear. The other is a plain user flag. Neither bit takes part in arbitration.

Top module: `groupIrqPrio`

## Requirements
- R1: Source `s` belongs to group `s % 6`. Group `g` has level `{prioHi[g], prioLo[g]}` (0..3, 3 highest), and the pending enabled source with the highest level is offered on `irqVec`/`irqLevel` with `irqReq` high.
- R2: Among pending enabled sources at the same highest level, the one with the lowest index is offered.
- R3: Reset clears the flags, both priority registers, the in-service mask and `irqReq`. With both priority registers zero, every group is at level 0 and the lowest pending index wins.
- R4: A one on `srcSet[i]` sets flag `i`. A flag write clears exactly the flags whose `flagWrData` bit is 0, and a data bit of 1 leaves the flag unchanged. A hardware set in the same cycle as a clear wins.
- R5: A flag whose `srcEn` bit is 0 stays latched but raises no request.
- R6: `prioLo` bit 6 is set by `wdogOvf` and cleared only by a low-register write with data bit 6 equal to 0. A written 1 does not set it. `prioLo` bit 7 is a plain read/write bit. Neither bit affects arbitration.
- R7: `prioHi` bits 7 and 6 always read as zero.
- R8: A request is offered only if its level is strictly above the highest level in service, or if nothing is in service. When `ack` is high while `irqReq` is high, the in-service bit of `irqLevel` is set and `irqReq` is low in the following cycle.
- R9: A `reti` pulse clears the highest set in-service bit.
- R10: The arbitration result is registered. A flag or priority change made at one clock edge is reflected on `irqReq`/`irqVec`/`irqLevel` after the next edge. `irqVec` and `irqLevel` read zero while `irqReq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcSet | input | 12 | Hardware set pulses, one per source |
| srcEn | input | 12 | Per-source request enables |
| flagWr | input | 1 | Flag register write strobe |
| flagWrData | input | 12 | Flag write data (0 clears) |
| loWr | input | 1 | Low priority register write strobe |
| hiWr | input | 1 | High priority register write strobe |
| prioWrData | input | 8 | Priority register write data |
| wdogOvf | input | 1 | Watchdog overflow pulse |
| ack | input | 1 | Core accepts the offered request |
| reti | input | 1 | Core returns from an interrupt |
| flags | output | 12 | Latched request flags |
| prioLo | output | 8 | Low priority register readback |
| prioHi | output | 8 | High priority register readback |
| inService | output | 4 | In-service level mask |
| irqReq | output | 1 | Interrupt request to the core |
| irqVec | output | 4 | Offered source index |
| irqLevel | output | 2 | Offered level |

## Verification
The bench walks a nested chain through all four levels. A design that compared levels with `>=` would offer a second level-3 request while level 3 is in service, and one that popped the lowest in-service bit on `reti` would leave the wrong mask behind. It races a hardware set against a software clear of the same flag, and pulses the watchdog and writes the user bit, because an implementation that let those bits into the level decode would move the winner. It also checks the one-cycle lag after a register write and checks that a mid-run reset brings back the natural order. Random traffic is then compared every cycle against a bench model.

// File: rtl/groupIrqPkg.sv
package groupIrqPkg;
  typedef struct packed {
    logic flagWr;
    logic loWr;
    logic hiWr;
    logic svcPush;
    logic svcPop;
  } ctrlStrobes_t;
endpackage

// File: rtl/groupIrqResolve.sv
module groupIrqResolve #(
  parameter int NUM_GROUPS = 6,
  parameter int NUM_SRC    = 12,
  parameter int IDX_W      = 4
) (
  input  logic [NUM_SRC-1:0]      pending,
  input  logic [2*NUM_GROUPS-1:0] groupLvl,
  output logic                    found,
  output logic [IDX_W-1:0]        winIdx,
  output logic [1:0]              winLvl
);
  logic [1:0] srcLvl [NUM_SRC];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_map
    assign srcLvl[s] = groupLvl[2*(s % NUM_GROUPS) +: 2];
  end

  // Ascending level pass lets higher levels overwrite; descending index scan
  // leaves the lowest index as the last hit within a level.
  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    winLvl = '0;
    for (int lv = 0; lv < 4; lv++) begin
      for (int s = NUM_SRC - 1; s >= 0; s--) begin
        if (pending[s] && srcLvl[s] == 2'(lv)) begin
          found  = 1'b1;
          winIdx = IDX_W'(s);
          winLvl = 2'(lv);
        end
      end
    end
  end
endmodule

// File: rtl/groupIrqCtrl.sv
module groupIrqCtrl
  import groupIrqPkg::*;
(
  input  logic         flagWr,
  input  logic         loWr,
  input  logic         hiWr,
  input  logic         ack,
  input  logic         reti,
  input  logic         irqReq,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.flagWr  = flagWr;
    strobes.loWr    = loWr;
    strobes.hiWr    = hiWr;
    strobes.svcPush = ack & irqReq;
    strobes.svcPop  = reti;
  end
endmodule

// File: rtl/groupIrqDatapath.sv
module groupIrqDatapath
  import groupIrqPkg::*;
#(
  parameter int NUM_GROUPS = 6,
  parameter int NUM_SRC    = 12,
  parameter int IDX_W      = 4,
  parameter int REG_W      = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strobes,
  input  logic [NUM_SRC-1:0]      srcSet,
  input  logic [NUM_SRC-1:0]      srcEn,
  input  logic [NUM_SRC-1:0]      flagWrData,
  input  logic [REG_W-1:0]        prioWrData,
  input  logic                    wdogOvf,
  input  logic                    found,
  input  logic [IDX_W-1:0]        winIdx,
  input  logic [1:0]              winLvl,
  output logic [NUM_SRC-1:0]      pending,
  output logic [2*NUM_GROUPS-1:0] groupLvl,
  output logic [NUM_SRC-1:0]      flags,
  output logic [REG_W-1:0]        prioLo,
  output logic [REG_W-1:0]        prioHi,
  output logic [3:0]              inService,
  output logic                    irqReq,
  output logic [IDX_W-1:0]        irqVec,
  output logic [1:0]              irqLevel
);
  localparam int USR_BIT = REG_W - 1;
  localparam int WD_BIT  = REG_W - 2;

  logic [NUM_GROUPS-1:0] hiGrp;
  logic [REG_W-1:0]      loNext;
  logic [3:0]            popMask, pushMask;
  logic                  okToIssue, issue;

  function automatic logic [1:0] topLevel(input logic [3:0] m);
    topLevel = '0;
    for (int i = 0; i < 4; i++) if (m[i]) topLevel = 2'(i);
  endfunction

  assign pending = flags & srcEn;
  assign prioHi  = REG_W'(hiGrp);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lvl
    assign groupLvl[2*g +: 2] = {hiGrp[g], prioLo[g]};
  end

  always_comb begin
    loNext = prioLo;
    if (strobes.loWr) begin
      loNext[NUM_GROUPS-1:0] = prioWrData[NUM_GROUPS-1:0];
      loNext[USR_BIT]        = prioWrData[USR_BIT];
      loNext[WD_BIT]         = prioLo[WD_BIT] & prioWrData[WD_BIT];
    end
    loNext[WD_BIT] = loNext[WD_BIT] | wdogOvf;
  end

  always_comb begin
    popMask = '0;
    for (int i = 0; i < 4; i++) if (inService[i]) popMask = 4'(1) << i;
    if (!strobes.svcPop) popMask = '0;
    pushMask  = strobes.svcPush ? (4'(1) << irqLevel) : 4'b0;
    okToIssue = (inService == '0) || (winLvl > topLevel(inService));
    issue     = found && okToIssue && !strobes.svcPush && !strobes.svcPop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags     <= '0;
      prioLo    <= '0;
      hiGrp     <= '0;
      inService <= '0;
      irqReq    <= 1'b0;
      irqVec    <= '0;
      irqLevel  <= '0;
    end else begin
      flags     <= (strobes.flagWr ? (flags & flagWrData) : flags) | srcSet;
      prioLo    <= loNext;
      if (strobes.hiWr) hiGrp <= prioWrData[NUM_GROUPS-1:0];
      inService <= (inService & ~popMask) | pushMask;
      irqReq    <= issue;
      irqVec    <= issue ? winIdx : '0;
      irqLevel  <= issue ? winLvl : '0;
    end
  end

  // R4
  set_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSet != '0) |=> ((flags & $past(srcSet)) == $past(srcSet)));
  // R8
  preempt_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (inService == '0 || irqLevel > topLevel(inService)));
  // R8
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.svcPush |=> (!irqReq && inService[$past(irqLevel)]));
  // R9
  pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.svcPop && !strobes.svcPush && inService != '0)
      |=> ($countones(inService) == $countones($past(inService)) - 1));
  // R6
  wdog_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdogOvf |=> prioLo[WD_BIT]);
endmodule

// File: rtl/groupIrqPrio.sv
module groupIrqPrio
  import groupIrqPkg::*;
#(
  parameter int NUM_GROUPS     = 6,
  parameter int SRCS_PER_GROUP = 2,
  parameter int REG_W          = 8,
  localparam int NUM_SRC       = NUM_GROUPS * SRCS_PER_GROUP,
  localparam int IDX_W         = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic               flagWr,
  input  logic [NUM_SRC-1:0] flagWrData,
  input  logic               loWr,
  input  logic               hiWr,
  input  logic [REG_W-1:0]   prioWrData,
  input  logic               wdogOvf,
  input  logic               ack,
  input  logic               reti,
  output logic [NUM_SRC-1:0] flags,
  output logic [REG_W-1:0]   prioLo,
  output logic [REG_W-1:0]   prioHi,
  output logic [3:0]         inService,
  output logic               irqReq,
  output logic [IDX_W-1:0]   irqVec,
  output logic [1:0]         irqLevel
);
  ctrlStrobes_t            strobes;
  logic [NUM_SRC-1:0]      pending;
  logic [2*NUM_GROUPS-1:0] groupLvl;
  logic                    found;
  logic [IDX_W-1:0]        winIdx;
  logic [1:0]              winLvl;

  groupIrqCtrl u_ctrl (
    .flagWr (flagWr),
    .loWr   (loWr),
    .hiWr   (hiWr),
    .ack    (ack),
    .reti   (reti),
    .irqReq (irqReq),
    .strobes(strobes)
  );

  groupIrqResolve #(
    .NUM_GROUPS(NUM_GROUPS), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)
  ) u_resolve (
    .pending (pending),
    .groupLvl(groupLvl),
    .found   (found),
    .winIdx  (winIdx),
    .winLvl  (winLvl)
  );

  groupIrqDatapath #(
    .NUM_GROUPS(NUM_GROUPS), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .REG_W(REG_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .srcSet    (srcSet),
    .srcEn     (srcEn),
    .flagWrData(flagWrData),
    .prioWrData(prioWrData),
    .wdogOvf   (wdogOvf),
    .found     (found),
    .winIdx    (winIdx),
    .winLvl    (winLvl),
    .pending   (pending),
    .groupLvl  (groupLvl),
    .flags     (flags),
    .prioLo    (prioLo),
    .prioHi    (prioHi),
    .inService (inService),
    .irqReq    (irqReq),
    .irqVec    (irqVec),
    .irqLevel  (irqLevel)
  );
endmodule

// File: tb/test_groupIrqPrio.sv
`timescale 1ns/1ps
module test_groupIrqPrio;
  localparam int NG = 6;
  localparam int NS = 12;

  logic clk = 1'b0;
  logic rstN;
  logic [NS-1:0] srcSet, srcEn, flagWrData, flags;
  logic flagWr, loWr, hiWr, wdogOvf, ack, reti, irqReq;
  logic [7:0] prioWrData, prioLo, prioHi;
  logic [3:0] inService, irqVec;
  logic [1:0] irqLevel;

  int total = 0;
  int bad = 0;

  // bench model
  logic [NS-1:0] mFlags;
  logic [7:0] mLo, mHi;
  logic [3:0] mSvc;
  logic eReq;
  logic [3:0] eVec;
  logic [1:0] eLvl;

  always #4 clk = ~clk;

  groupIrqPrio i_groupIrqPrio (
    .clk(clk), .rstN(rstN), .srcSet(srcSet), .srcEn(srcEn), .flagWr(flagWr),
    .flagWrData(flagWrData), .loWr(loWr), .hiWr(hiWr), .prioWrData(prioWrData),
    .wdogOvf(wdogOvf), .ack(ack), .reti(reti), .flags(flags), .prioLo(prioLo),
    .prioHi(prioHi), .inService(inService), .irqReq(irqReq), .irqVec(irqVec),
    .irqLevel(irqLevel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] resolveExp();
    logic [6:0] r = '0;
    logic [NS-1:0] p = mFlags & srcEn;
    for (int lv = 0; lv < 4; lv++)
      for (int s = NS - 1; s >= 0; s--)
        if (p[s] && {mHi[s % NG], mLo[s % NG]} == 2'(lv)) r = {1'b1, 2'(lv), 4'(s)};
    return r;
  endfunction

  function automatic logic [1:0] topOf(input logic [3:0] m);
    logic [1:0] t = '0;
    for (int i = 0; i < 4; i++) if (m[i]) t = 2'(i);
    return t;
  endfunction

  task automatic modelReset();
    mFlags = '0; mLo = '0; mHi = '0; mSvc = '0;
    eReq = 1'b0; eVec = '0; eLvl = '0;
  endtask

  task automatic cyc(input logic [NS-1:0] set, input logic fw, input logic [NS-1:0] fd,
                     input logic lw, input logic hw, input logic [7:0] pd,
                     input logic wd, input logic ak, input logic rt);
    logic [6:0] r;
    logic ok, nReq;
    logic [3:0] pop;
    srcSet = set; flagWr = fw; flagWrData = fd; loWr = lw; hiWr = hw;
    prioWrData = pd; wdogOvf = wd; ack = ak; reti = rt;
    @(posedge clk);
    r = resolveExp();
    ok = (mSvc == 0) || (r[5:4] > topOf(mSvc));
    nReq = r[6] && ok && !(ak && eReq) && !rt;
    pop = '0;
    for (int i = 0; i < 4; i++) if (mSvc[i]) pop = 4'(1) << i;
    if (!rt) pop = '0;
    mSvc = (mSvc & ~pop) | ((ak && eReq) ? (4'(1) << eLvl) : 4'b0);
    eReq = nReq;
    eVec = nReq ? r[3:0] : 4'd0;
    eLvl = nReq ? r[5:4] : 2'd0;
    mFlags = (fw ? (mFlags & fd) : mFlags) | set;
    if (lw) mLo = {pd[7], mLo[6] & pd[6], pd[5:0]};
    mLo[6] = mLo[6] | wd;
    if (hw) mHi = {2'b00, pd[5:0]};
    @(negedge clk);
    srcSet = '0; flagWr = 0; flagWrData = '0; loWr = 0; hiWr = 0;
    prioWrData = '0; wdogOvf = 0; ack = 0; reti = 0;
  endtask

  task automatic idle(); cyc('0, 0, '0, 0, 0, '0, 0, 0, 0); endtask
  task automatic setF(input logic [NS-1:0] s); cyc(s, 0, '0, 0, 0, '0, 0, 0, 0); endtask
  task automatic wrLo(input logic [7:0] d); cyc('0, 0, '0, 1, 0, d, 0, 0, 0); endtask
  task automatic wrHi(input logic [7:0] d); cyc('0, 0, '0, 0, 1, d, 0, 0, 0); endtask
  task automatic wrF(input logic [NS-1:0] d); cyc('0, 1, d, 0, 0, '0, 0, 0, 0); endtask
  task automatic doAck(); cyc('0, 0, '0, 0, 0, '0, 0, 1, 0); endtask
  task automatic doReti(); cyc('0, 0, '0, 0, 0, '0, 0, 0, 1); endtask

  task automatic chkIrq(input string tag, input logic q, input logic [3:0] v, input logic [1:0] l);
    chk({tag, " irqReq"}, 32'(irqReq), 32'(q));
    chk({tag, " irqVec"}, 32'(irqVec), 32'(v));
    chk({tag, " irqLevel"}, 32'(irqLevel), 32'(l));
  endtask

  task automatic doReset();
    rstN = 1'b0;
    srcSet = '0; flagWr = 0; flagWrData = '0; loWr = 0; hiWr = 0;
    prioWrData = '0; wdogOvf = 0; ack = 0; reti = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7319));
    srcEn = '1;
    doReset();
    // R3 reset state
    chk("R3 flags", 32'(flags), 0);
    chk("R3 prioLo", 32'(prioLo), 0);
    chk("R3 prioHi", 32'(prioHi), 0);
    chk("R3 inService", 32'(inService), 0);
    chk("R3 irqReq", 32'(irqReq), 0);

    // R10 flags latched, request one edge later; R2/R3 natural order
    setF(12'h024);
    chk("R4 flags set", 32'(flags), 32'h024);
    chk("R10 request lag", 32'(irqReq), 0);
    idle();
    chkIrq("R2 natural order", 1, 2, 0);

    // R1 and R10 priority write timing
    wrLo(8'h20);
    wrHi(8'h20);
    chkIrq("R10 write lag", 1, 5, 1);
    idle();
    chkIrq("R1 group level 3", 1, 5, 3);

    // R7 unused high bits
    wrHi(8'hFF);
    chk("R7 prioHi", 32'(prioHi), 32'h3F);
    wrHi(8'h20);

    // R6 watchdog and user bits
    cyc('0, 0, '0, 0, 0, '0, 1, 0, 0);
    chk("R6 wdog set", 32'(prioLo), 32'h60);
    idle();
    chkIrq("R6 wdog no effect", 1, 5, 3);
    wrLo(8'hE0);
    chk("R6 write one keeps", 32'(prioLo), 32'hE0);
    idle();
    chkIrq("R6 user bit no effect", 1, 5, 3);
    wrLo(8'hA0);
    chk("R6 write zero clears", 32'(prioLo), 32'hA0);

    // R4 set beats clear, write of one keeps, write of zero clears
    cyc(12'h020, 1, ~12'h020, 0, 0, '0, 0, 0, 0);
    chk("R4 set wins", 32'(flags), 32'h024);
    wrF(12'hFFF);
    chk("R4 one keeps", 32'(flags), 32'h024);
    wrF(~12'h020);
    chk("R4 zero clears", 32'(flags), 32'h004);
    idle();
    chkIrq("R4 after clear", 1, 2, 0);

    // R5 enable gating
    srcEn = ~12'h004;
    idle(); idle();
    chkIrq("R5 disabled", 0, 0, 0);
    chk("R5 flag kept", 32'(flags), 32'h004);
    srcEn = '1;
    wrF(12'h000); wrLo(8'h00); wrHi(8'h00);

    // R8/R9 nesting: group g at level g%4
    wrLo(8'h2A); wrHi(8'h0C);
    setF(12'h001); idle();
    chkIrq("R8 level0 offered", 1, 0, 0);
    doAck();
    chk("R8 ack drops req", 32'(irqReq), 0);
    chk("R8 svc0", 32'(inService), 32'h1);
    idle();
    chk("R8 equal level blocked", 32'(irqReq), 0);
    setF(12'h002); idle();
    chkIrq("R8 level1 preempts", 1, 1, 1);
    doAck();
    setF(12'h004); idle();
    chkIrq("R8 level2 preempts", 1, 2, 2);
    doAck();
    setF(12'h008); idle();
    chkIrq("R8 level3 preempts", 1, 3, 3);
    doAck();
    chk("R8 svc all", 32'(inService), 32'hF);
    setF(12'h200); idle();
    chk("R8 level3 blocked", 32'(irqReq), 0);
    doReti();
    chk("R9 pop top", 32'(inService), 32'h7);
    idle();
    chkIrq("R2 tie at level3", 1, 3, 3);
    doReti(); doReti();
    chk("R9 pop twice", 32'(inService), 32'h1);
    doReti();
    chk("R9 empty", 32'(inService), 32'h0);

    // R3 mid-run reset restores natural order
    wrHi(8'h3F); wrLo(8'h20);
    doReset();
    chk("R3 reset prio", 32'({prioHi, prioLo}), 0);
    setF(12'h030); idle();
    chkIrq("R3 natural after reset", 1, 4, 0);

    // random traffic against model (R1 R2 R4 R5 R8 R9 R10)
    doReset();
    for (int it = 0; it < 600; it++) begin
      logic [NS-1:0] s;
      logic ak, rt;
      if ($urandom % 25 == 0) srcEn = NS'($urandom) | NS'($urandom);
      s  = ($urandom % 3 == 0) ? (NS'($urandom) & NS'($urandom) & NS'($urandom)) : '0;
      ak = eReq && ($urandom % 3 == 0);
      rt = !ak && (mSvc != 0) && ($urandom % 4 == 0);
      cyc(s, ($urandom % 6 == 0), NS'($urandom), ($urandom % 10 == 0),
          ($urandom % 10 == 0), 8'($urandom), ($urandom % 20 == 0), ak, rt);
      chk("R1 rnd irqReq", 32'(irqReq), 32'(eReq));
      chk("R2 rnd irqVec", 32'(irqVec), 32'(eVec));
      chk("R8 rnd irqLevel", 32'(irqLevel), 32'(eLvl));
      chk("R9 rnd inService", 32'(inService), 32'(mSvc));
      chk("R4 rnd flags", 32'(flags), 32'(mFlags));
      chk("R6 rnd prioLo", 32'(prioLo), 32'(mLo));
      chk("R7 rnd prioHi", 32'(prioHi), 32'(mHi));
    end

    summary();
    $finish;
  end
endmodule